// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

The block takes one fast source clock and produces three banks of four clock outputs (A, B and C) and one feedback output. Each of these four groups has its own even-ratio divider, and a small select bus chooses the ratio. All dividers produce a 50% duty cycle. They leave reset on the same source edge, so their edges stay in phase across banks.

A source mux picks either the oscillator or a reference clock to drive the dividers. When the oscillator is picked, a rate select can halve it first. This is done with a clock enable on every other oscillator edge. An active-low master reset clears all divider state and drops an output-enable flag, which the pad ring uses to tristate the pins. Two of the bank-C outputs can be inverted by a live control. The ratio, rate and source selects are captured while the block is in reset and are held from then on.

Top module: `mbcd_top`

## Requirements
- R1: Bank A select `sel_a_i` values 0, 1, 2 and 3 give output periods of 4, 6, 8 and 12 divider-input edges.
- R2: Bank B select `sel_b_i` values 0, 1, 2 and 3 give periods of 4, 6, 8 and 10 divider-input edges.
- R3: Bank C select `sel_c_i` values 0, 1, 2 and 3 give periods of 2, 4, 6 and 8 divider-input edges.
- R4: The feedback select `sel_fb_i` values 0 through 7 give periods of 4, 6, 8, 10, 8, 12, 16 and 20 divider-input edges.
- R5: With `use_osc_i`=1 and `full_rate_i`=0, the dividers advance on every second oscillator edge. With `full_rate_i`=1 they advance on every oscillator edge.
- R6: With `use_osc_i`=0, `ref_clk_i` drives the dividers and they advance on every reference edge, whatever the value of `full_rate_i`.
- R7: While `rst_ni` is low, `out_en_o` is 0 and every divider output is 0, apart from the inversion in R8. From the first source edge after release, `out_en_o` is 1.
- R8: When `inv_c_hi_i` is 1, bank-C outputs 2 and 3 are inverted. Bank-C outputs 0 and 1 are never inverted.
- R9: Every output has a 50% duty cycle. On the first divider-input edge after release, all outputs go high together. That edge is source edge 2 after release (edge 1 only starts the block).
- R10: Changing any ratio select while the block runs has no effect on the outputs until the next master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Fast oscillator clock |
| ref_clk_i | input | 1 | Reference clock used in bypass |
| rst_ni | input | 1 | Active-low master reset; also gates output enable |
| use_osc_i | input | 1 | 1: oscillator drives dividers; 0: reference drives them |
| full_rate_i | input | 1 | 1: oscillator undivided; 0: oscillator halved |
| sel_a_i | input | 2 | Bank A ratio select |
| sel_b_i | input | 2 | Bank B ratio select |
| sel_c_i | input | 2 | Bank C ratio select |
| sel_fb_i | input | 3 | Feedback ratio select |
| inv_c_hi_i | input | 1 | Inverts bank-C outputs 2 and 3 |
| bank_a_o | output | 4 | Bank A clocks |
| bank_b_o | output | 4 | Bank B clocks |
| bank_c_o | output | 4 | Bank C clocks |
| fb_o | output | 1 | Feedback clock |
| out_en_o | output | 1 | Output enable for the pad tristate |

## Verification
The assertions assume that `use_osc_i` and `full_rate_i` change only while `rst_ni` is low. The source mux is a plain combinational clock select, so its inputs must be static while the dividers run. The stimulus changes the source, the rate and all selects only inside reset, with several source edges of settling time before release. The one exception is the R10 case, which changes the ratio selects mid-run on purpose. It expects the outputs to keep following the ratios captured in reset.

// File: rtl/mbcd_pkg.sv
package mbcd_pkg;
  localparam int unsigned DIV_CNT_W = 4;

  typedef struct packed {
    logic       use_osc;
    logic       full;
    logic [1:0] a;
    logic [1:0] b;
    logic [1:0] c;
    logic [2:0] fb;
  } cfg_t;

  // half-period in divider-input edges
  function automatic logic [DIV_CNT_W-1:0] half_a(input logic [1:0] s);
    case (s)
      2'd0: return 4'd2;
      2'd1: return 4'd3;
      2'd2: return 4'd4;
      default: return 4'd6;
    endcase
  endfunction

  function automatic logic [DIV_CNT_W-1:0] half_b(input logic [1:0] s);
    case (s)
      2'd0: return 4'd2;
      2'd1: return 4'd3;
      2'd2: return 4'd4;
      default: return 4'd5;
    endcase
  endfunction

  function automatic logic [DIV_CNT_W-1:0] half_c(input logic [1:0] s);
    return DIV_CNT_W'(s) + 4'd1;
  endfunction

  function automatic logic [DIV_CNT_W-1:0] half_fb(input logic [2:0] s);
    case (s)
      3'd0: return 4'd2;
      3'd1: return 4'd3;
      3'd2: return 4'd4;
      3'd3: return 4'd5;
      3'd4: return 4'd4;
      3'd5: return 4'd6;
      3'd6: return 4'd8;
      default: return 4'd10;
    endcase
  endfunction
endpackage

// File: rtl/mbcd_seq.sv
module mbcd_seq
  import mbcd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  output cfg_t cfg_o,
  output logic run_o,
  output logic en_o
);
  logic run_q, pre_q;
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pre_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) pre_q <= ~pre_q;
    end
  end

  // selects track inputs only while idle
  always_ff @(posedge clk_i) begin
    if (!run_q) cfg_q <= cfg_i;
  end

  assign en_o  = run_q & (cfg_q.full | ~cfg_q.use_osc | ~pre_q);
  assign run_o = run_q;
  assign cfg_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(cfg_q)); // R10
  AST_PRE_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && cfg_q.use_osc && !cfg_q.full) |-> (en_o != $past(en_o))); // R5
endmodule

// File: rtl/mbcd_div.sv
module mbcd_div #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             q_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (en_i) begin
      if (cnt_q == '0) q_q <= ~q_q;
      cnt_q <= (cnt_q == half_i - 1'b1) ? '0 : cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (q_q == 1'b0 && cnt_q == '0)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half_i)); // R9
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(q_q) && $stable(cnt_q))); // R5
endmodule

// File: rtl/mbcd_top.sv
module mbcd_top
  import mbcd_pkg::*;
#(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned CNT_W  = DIV_CNT_W
) (
  input  logic              osc_clk_i,
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic              use_osc_i,
  input  logic              full_rate_i,
  input  logic [1:0]        sel_a_i,
  input  logic [1:0]        sel_b_i,
  input  logic [1:0]        sel_c_i,
  input  logic [2:0]        sel_fb_i,
  input  logic              inv_c_hi_i,
  output logic [BANK_W-1:0] bank_a_o,
  output logic [BANK_W-1:0] bank_b_o,
  output logic [BANK_W-1:0] bank_c_o,
  output logic              fb_o,
  output logic              out_en_o
);
  localparam int unsigned NUM_DIV = 4;
  localparam int unsigned INV_LO  = BANK_W / 2;

  logic             src_clk, run, en;
  cfg_t             cfg_in, cfg;
  logic [CNT_W-1:0] half [NUM_DIV];
  logic [NUM_DIV-1:0] q;

  // static select; only changed under reset
  assign src_clk = use_osc_i ? osc_clk_i : ref_clk_i;

  assign cfg_in = '{use_osc: use_osc_i, full: full_rate_i,
                    a: sel_a_i, b: sel_b_i, c: sel_c_i, fb: sel_fb_i};

  mbcd_seq u_seq (
    .clk_i (src_clk),
    .rst_ni(rst_ni),
    .cfg_i (cfg_in),
    .cfg_o (cfg),
    .run_o (run),
    .en_o  (en)
  );

  assign half[0] = CNT_W'(half_a(cfg.a));
  assign half[1] = CNT_W'(half_b(cfg.b));
  assign half[2] = CNT_W'(half_c(cfg.c));
  assign half[3] = CNT_W'(half_fb(cfg.fb));

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    mbcd_div #(.CNT_W(CNT_W)) u_div (
      .clk_i (src_clk),
      .rst_ni(rst_ni),
      .run_i (run),
      .en_i  (en),
      .half_i(half[g]),
      .q_o   (q[g])
    );
  end

  for (genvar i = 0; i < BANK_W; i++) begin : g_lane
    assign bank_a_o[i] = q[0];
    assign bank_b_o[i] = q[1];
    if (i >= INV_LO) begin : g_inv
      assign bank_c_o[i] = q[2] ^ inv_c_hi_i;
    end else begin : g_pass
      assign bank_c_o[i] = q[2];
    end
  end

  assign fb_o     = q[3];
  assign out_en_o = run;
endmodule

// File: tb/mbcd_top_tb.sv
module mbcd_top_tb;
  logic osc_clk = 1'b0, ref_clk = 1'b0, rst_ni = 1'b0;
  logic use_osc = 1'b1, full_rate = 1'b1, inv_c = 1'b0;
  logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
  logic [2:0] sel_fb = '0;
  logic [3:0] bank_a, bank_b, bank_c;
  logic fb, out_en;
  logic mon_clk, mon_on = 1'b0;
  int checks = 0, fails = 0;
  logic [13:0] sb[$];

  always #4 osc_clk = ~osc_clk;
  always #10 ref_clk = ~ref_clk;
  assign mon_clk = use_osc ? osc_clk : ref_clk;

  mbcd_top u_dut (
    .osc_clk_i(osc_clk), .ref_clk_i(ref_clk), .rst_ni(rst_ni),
    .use_osc_i(use_osc), .full_rate_i(full_rate),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_c_i(sel_c), .sel_fb_i(sel_fb),
    .inv_c_hi_i(inv_c), .bank_a_o(bank_a), .bank_b_o(bank_b),
    .bank_c_o(bank_c), .fb_o(fb), .out_en_o(out_en)
  );

  int ha[4]  = '{2, 3, 4, 6};
  int hb[4]  = '{2, 3, 4, 5};
  int hc[4]  = '{1, 2, 3, 4};
  int hfb[8] = '{2, 3, 4, 5, 4, 6, 8, 10};

  function automatic logic wave(int m, int h);
    if (m == 0) return 1'b0;
    return ((m - 1) % (2 * h)) < h;
  endfunction

  // monitor: pop one expected item per source edge
  always @(negedge mon_clk) begin
    if (mon_on && sb.size() > 0) begin
      logic [13:0] exp_v, act_v;
      string tag;
      exp_v = sb.pop_front();
      act_v = {out_en, fb, bank_c, bank_b, bank_a};
      checks++;
      if (act_v !== exp_v) begin
        fails++;
        if (act_v[13] !== exp_v[13]) tag = "R7";
        else if (act_v[3:0] !== exp_v[3:0]) tag = "R1";
        else if (act_v[7:4] !== exp_v[7:4]) tag = "R2";
        else if (act_v[9:8] !== exp_v[9:8]) tag = "R3";
        else if (act_v[11:10] !== exp_v[11:10]) tag = "R8";
        else tag = "R4";
        $display("FAIL %s: actual %b expected %b", tag, act_v, exp_v);
      end
    end
  end

  task automatic check_reset();
    checks++;
    if (out_en !== 1'b0 || bank_a !== 4'h0 || bank_b !== 4'h0 || fb !== 1'b0 ||
        bank_c !== {inv_c, inv_c, 2'b00}) begin
      fails++;
      $display("FAIL R7: actual %b expected %b", {out_en, fb, bank_c, bank_b, bank_a},
               {1'b0, 1'b0, inv_c, inv_c, 10'b0});
    end
  endtask

  // driver: configure under reset, push expectations, release
  task automatic run_case(input logic osc, input logic full, input logic [1:0] a,
                          input logic [1:0] b, input logic [1:0] c,
                          input logic [2:0] f, input logic inv, input int n,
                          input bit alter);
    rst_ni = 1'b0; mon_on = 1'b0;
    use_osc = osc; full_rate = full; inv_c = inv;
    sel_a = a; sel_b = b; sel_c = c; sel_fb = f;
    repeat (4) @(negedge mon_clk);
    check_reset(); // R7
    for (int e = 1; e <= n; e++) begin
      int m;
      logic qa, qb, qc, qf;
      if (e < 2) m = 0;
      else if (!osc || full) m = e - 1;   // R6 ref undivided
      else m = e / 2;                     // R5 halved
      qa = wave(m, ha[a]); qb = wave(m, hb[b]);
      qc = wave(m, hc[c]); qf = wave(m, hfb[f]);
      sb.push_back({1'b1, qf, qc ^ inv, qc ^ inv, qc, qc, {4{qb}}, {4{qa}}});
    end
    @(negedge mon_clk);
    rst_ni = 1'b1;
    #1 mon_on = 1'b1;
    if (alter) begin // R10 mid-run change ignored
      repeat (9) @(negedge mon_clk);
      #1;
      sel_a = ~a; sel_b = ~b; sel_c = ~c; sel_fb = ~f;
    end
    while (sb.size() != 0) begin
      @(negedge mon_clk);
      #2;
    end
    mon_on = 1'b0;
  endtask

  initial begin
    // R1 R2 R3 R4 R9: ratio sweeps at full rate
    run_case(1, 1, 2'd0, 2'd0, 2'd0, 3'd0, 0, 48, 0);
    run_case(1, 1, 2'd1, 2'd1, 2'd1, 3'd1, 1, 48, 0); // R8
    run_case(1, 1, 2'd2, 2'd2, 2'd2, 3'd2, 0, 48, 0);
    run_case(1, 1, 2'd3, 2'd3, 2'd3, 3'd3, 1, 48, 0);
    run_case(1, 1, 2'd0, 2'd3, 2'd1, 3'd4, 0, 48, 0);
    run_case(1, 1, 2'd3, 2'd0, 2'd2, 3'd5, 0, 48, 0);
    run_case(1, 1, 2'd1, 2'd2, 2'd3, 3'd6, 1, 56, 0);
    run_case(1, 1, 2'd2, 2'd1, 2'd0, 3'd7, 0, 64, 0);
    // R5 halved oscillator
    run_case(1, 0, 2'd3, 2'd3, 2'd3, 3'd7, 1, 90, 0);
    run_case(1, 0, 2'd0, 2'd1, 2'd0, 3'd2, 0, 60, 0);
    // R6 reference bypass, rate select has no effect
    run_case(0, 0, 2'd1, 2'd3, 2'd1, 3'd5, 1, 48, 0);
    run_case(0, 1, 2'd3, 2'd2, 2'd0, 3'd3, 0, 48, 0);
    // R10 selects changed while running
    run_case(1, 1, 2'd1, 2'd2, 2'd1, 3'd6, 0, 60, 1);
    run_case(1, 0, 2'd3, 2'd0, 2'd3, 3'd1, 1, 60, 1);
    rst_ni = 1'b0;
    repeat (2) @(negedge mon_clk);
    check_reset(); // R7 re-entry
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule